// File: doc/BRIEF.md
# Dual-Clock Mailbox Bypass Registers

This block carries single 36-bit words between two ports that run on unrelated clocks, outside the FIFO path. Port A loads the first mailbox and reads the second. Port B loads the second mailbox and reads the first. Each mailbox has an active-low full flag. The flag belongs to the writing clock domain: the writer's own edge drives it low, and a read on the far side drives it high again. While a mailbox shows full, further loads into it are dropped, so the reader always gets the word that was first deposited.

Each mailbox is a two-state machine on the writer side (`WS_EMPTY`, `WS_FULL`) and a two-state machine on the reader side (`RS_IDLE`, `RS_HELD`). A load on an empty mailbox takes `WS_EMPTY -> WS_FULL` and flips a set toggle. The reader synchronises that toggle, takes `RS_IDLE -> RS_HELD`, and on its next mailbox read takes `RS_HELD -> RS_IDLE` and flips a clear toggle. The writer synchronises the clear toggle and takes `WS_FULL -> WS_EMPTY`. Port B reads with the mailbox select low return the FIFO output word on `fifo_q_b` instead of the first mailbox.

Top module: `mbox_bypass`

## Requirements
- R1: A port A access (cs_a_n=0, en_a=1, wr_a=1, mbsel_a=1) while mb1_full_n is 1 stores din_a in the first mailbox and drives mb1_full_n to 0 at that clk_a edge.
- R2: A port A load of the first mailbox while mb1_full_n is 0 is dropped: the stored word and the flag are unchanged.
- R3: A port B access (cs_b_n=0, en_b=1, rd_b=1, mbsel_b=1) loads dout_b with the first mailbox at that clk_b edge; if that mailbox held an unread word, mb1_full_n stays 0 through the second clk_a rising edge after the read edge and is 1 after the third (two synchroniser stages).
- R4: A port B access with rd_b=0 and mbsel_b=1 while mb2_full_n is 1 stores din_b in the second mailbox and drives mb2_full_n to 0 at that clk_b edge; while mb2_full_n is 0 such loads are dropped.
- R5: A port A access with wr_a=0 and mbsel_a=1 loads dout_a with the second mailbox; if it held an unread word, mb2_full_n stays 0 through the second clk_b rising edge after the read edge and is 1 after the third.
- R6: A port B read with mbsel_b=0 loads dout_b with fifo_q_b and leaves both mailboxes and flags unchanged.
- R7: A mailbox read while its flag is 1 returns the last stored word and leaves the flag at 1.
- R8: An edge with the chip select high or the enable low changes no output and no mailbox.
- R9: Master reset (master_rst_n=0) sets both flags to 1, both data outputs to 0 and the first mailbox word to 0; partial reset (part_rst_n=0) sets both flags to 1 and both data outputs to 0 but keeps both mailbox words.
- R10: mail2_clr_n=0 clears the second mailbox word to 0 without changing either flag.
- R11: Port A loads with mbsel_a=0 and port B writes with mbsel_b=0 leave both mailboxes and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| master_rst_n | input | 1 | Master reset, active low, asynchronous assert |
| part_rst_n | input | 1 | Partial reset, active low, keeps mailbox words |
| mail2_clr_n | input | 1 | Clears the second mailbox word, active low |
| clk_a | input | 1 | Port A clock |
| cs_a_n | input | 1 | Port A chip select, active low |
| en_a | input | 1 | Port A enable |
| wr_a | input | 1 | Port A direction: 1 load, 0 read |
| mbsel_a | input | 1 | Port A mailbox select |
| din_a | input | 36 | Port A write data |
| dout_a | output | 36 | Port A read data register |
| mb1_full_n | output | 1 | First mailbox full flag, active low, clk_a domain |
| clk_b | input | 1 | Port B clock |
| cs_b_n | input | 1 | Port B chip select, active low |
| en_b | input | 1 | Port B enable |
| rd_b | input | 1 | Port B direction: 1 read, 0 load |
| mbsel_b | input | 1 | Port B mailbox select |
| din_b | input | 36 | Port B write data |
| fifo_q_b | input | 36 | FIFO output word routed on non-mailbox reads |
| dout_b | output | 36 | Port B read data register |
| mb2_full_n | output | 1 | Second mailbox full flag, active low, clk_b domain |

## Verification
Loads, reads and FIFO routing take effect at the access edge itself, so the bench samples flags and data at the falling edge right after that edge. A release crosses domains and lands on the third rising edge of the writer's clock after the read edge; the bench counts writer-clock edges from the read edge, checks the flag still low after the second and high after the third. Between random operations the bench waits several cycles of both clocks so the model state is settled before the next access, and reset and clear effects are checked after their synchronisers have released.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic {
        WS_EMPTY = 1'b0,
        WS_FULL  = 1'b1
    } wr_state_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_HELD = 1'b1
    } rd_state_e;

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], 1'b1};
    end

    assign rst_n = chain_q[LAST];
endmodule

// File: rtl/mbox_bit_sync.sv
module mbox_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d};
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/mbox_writer.sv
module mbox_writer
    import mbox_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] din,
    input  logic              clr_tgl_in,
    output logic              set_tgl_out,
    output logic              full_n,
    output logic [DATA_W-1:0] data_q
);
    wr_state_e state_q, state_d;
    logic      clr_sync, clr_seen_q, clr_evt, fill;

    mbox_bit_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (clr_tgl_in),
        .q    (clr_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_seen_q <= 1'b0;
        else        clr_seen_q <= clr_sync;
    end

    assign clr_evt = clr_sync ^ clr_seen_q;

    // transitions: FILL (EMPTY->FULL on load), RELEASE (FULL->EMPTY on clear event)
    always_comb begin
        state_d = state_q;
        fill    = 1'b0;
        unique case (state_q)
            WS_EMPTY: begin
                if (wr_req) begin
                    state_d = WS_FULL;
                    fill    = 1'b1;
                end
            end
            WS_FULL: begin
                if (clr_evt) state_d = WS_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    set_tgl_out <= 1'b0;
        else if (fill) set_tgl_out <= ~set_tgl_out;
    end

    always_ff @(posedge clk or negedge data_rst_n) begin
        if (!data_rst_n) data_q <= '0;
        else if (fill)   data_q <= din;
    end

    always_comb begin
        full_n = (state_q == WS_EMPTY);
    end
endmodule

// File: rtl/mbox_reader.sv
module mbox_reader
    import mbox_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tgl_in,
    input  logic rd_req,
    output logic clr_tgl_out
);
    rd_state_e state_q, state_d;
    logic      set_sync, set_seen_q, set_evt, drain;

    mbox_bit_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (set_tgl_in),
        .q    (set_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) set_seen_q <= 1'b0;
        else        set_seen_q <= set_sync;
    end

    assign set_evt = set_sync ^ set_seen_q;

    // transitions: ARRIVE (IDLE->HELD on set event), CONSUME (HELD->IDLE on read)
    always_comb begin
        state_d = state_q;
        drain   = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (set_evt) state_d = RS_HELD;
            end
            RS_HELD: begin
                if (rd_req) begin
                    state_d = RS_IDLE;
                    drain   = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     clr_tgl_out <= 1'b0;
        else if (drain) clr_tgl_out <= ~clr_tgl_out;
    end
endmodule

// File: rtl/mbox_bypass.sv
module mbox_bypass #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              master_rst_n,
    input  logic              part_rst_n,
    input  logic              mail2_clr_n,
    input  logic              clk_a,
    input  logic              cs_a_n,
    input  logic              en_a,
    input  logic              wr_a,
    input  logic              mbsel_a,
    input  logic [DATA_W-1:0] din_a,
    output logic [DATA_W-1:0] dout_a,
    output logic              mb1_full_n,
    input  logic              clk_b,
    input  logic              cs_b_n,
    input  logic              en_b,
    input  logic              rd_b,
    input  logic              mbsel_b,
    input  logic [DATA_W-1:0] din_b,
    input  logic [DATA_W-1:0] fifo_q_b,
    output logic [DATA_W-1:0] dout_b,
    output logic              mb2_full_n
);
    localparam int RST_STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic flag_arst_n;
    logic rst_a_n, rst_b_n, m1_data_rst_n, m2_data_rst_n;
    logic acc_a, acc_b;
    logic a_m1_wr, a_m2_rd, b_m2_wr, b_m1_rd, b_fifo_rd;
    logic m1_set_tgl, m1_clr_tgl, m2_set_tgl, m2_clr_tgl;
    logic [DATA_W-1:0] mail1_q, mail2_q;

    assign flag_arst_n = master_rst_n & part_rst_n;

    mbox_rst_sync #(.STAGES(RST_STAGES)) u_rst_a (
        .clk(clk_a), .arst_n(flag_arst_n), .rst_n(rst_a_n)
    );
    mbox_rst_sync #(.STAGES(RST_STAGES)) u_rst_b (
        .clk(clk_b), .arst_n(flag_arst_n), .rst_n(rst_b_n)
    );
    mbox_rst_sync #(.STAGES(RST_STAGES)) u_rst_m1 (
        .clk(clk_a), .arst_n(master_rst_n), .rst_n(m1_data_rst_n)
    );
    mbox_rst_sync #(.STAGES(RST_STAGES)) u_rst_m2 (
        .clk(clk_b), .arst_n(mail2_clr_n), .rst_n(m2_data_rst_n)
    );

    assign acc_a     = ~cs_a_n & en_a;
    assign acc_b     = ~cs_b_n & en_b;
    assign a_m1_wr   = acc_a &  wr_a & mbsel_a;
    assign a_m2_rd   = acc_a & ~wr_a & mbsel_a;
    assign b_m2_wr   = acc_b & ~rd_b & mbsel_b;
    assign b_m1_rd   = acc_b &  rd_b & mbsel_b;
    assign b_fifo_rd = acc_b &  rd_b & ~mbsel_b;

    // first mailbox: written from port A, read from port B
    mbox_writer #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_m1_wr (
        .clk        (clk_a),
        .rst_n      (rst_a_n),
        .data_rst_n (m1_data_rst_n),
        .wr_req     (a_m1_wr),
        .din        (din_a),
        .clr_tgl_in (m1_clr_tgl),
        .set_tgl_out(m1_set_tgl),
        .full_n     (mb1_full_n),
        .data_q     (mail1_q)
    );
    mbox_reader #(.SYNC_STAGES(SYNC_STAGES)) u_m1_rd (
        .clk        (clk_b),
        .rst_n      (rst_b_n),
        .set_tgl_in (m1_set_tgl),
        .rd_req     (b_m1_rd),
        .clr_tgl_out(m1_clr_tgl)
    );

    // second mailbox: written from port B, read from port A
    mbox_writer #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_m2_wr (
        .clk        (clk_b),
        .rst_n      (rst_b_n),
        .data_rst_n (m2_data_rst_n),
        .wr_req     (b_m2_wr),
        .din        (din_b),
        .clr_tgl_in (m2_clr_tgl),
        .set_tgl_out(m2_set_tgl),
        .full_n     (mb2_full_n),
        .data_q     (mail2_q)
    );
    mbox_reader #(.SYNC_STAGES(SYNC_STAGES)) u_m2_rd (
        .clk        (clk_a),
        .rst_n      (rst_a_n),
        .set_tgl_in (m2_set_tgl),
        .rd_req     (a_m2_rd),
        .clr_tgl_out(m2_clr_tgl)
    );

    always_ff @(posedge clk_a or negedge rst_a_n) begin
        if (!rst_a_n)     dout_a <= '0;
        else if (a_m2_rd) dout_a <= mail2_q;
    end

    always_ff @(posedge clk_b or negedge rst_b_n) begin
        if (!rst_b_n)       dout_b <= '0;
        else if (b_m1_rd)   dout_b <= mail1_q;
        else if (b_fifo_rd) dout_b <= fifo_q_b;
    end
endmodule

// File: rtl/mbox_bypass_chk.sv
module mbox_bypass_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_a_n,
    input logic              rst_b_n,
    input logic              m2_data_rst_n,
    input logic              a_m1_wr,
    input logic              a_m2_rd,
    input logic              b_m2_wr,
    input logic              b_m1_rd,
    input logic              b_fifo_rd,
    input logic              mb1_full_n,
    input logic              mb2_full_n,
    input logic [DATA_W-1:0] din_a,
    input logic [DATA_W-1:0] din_b,
    input logic [DATA_W-1:0] fifo_q_b,
    input logic [DATA_W-1:0] mail1_q,
    input logic [DATA_W-1:0] mail2_q,
    input logic [DATA_W-1:0] dout_a,
    input logic [DATA_W-1:0] dout_b
);
    AST_M1_LOAD_FILLS: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_m1_wr && mb1_full_n) |=> (!mb1_full_n && mail1_q == $past(din_a))); // R1

    AST_M1_LOAD_BLOCKED: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_m1_wr && !mb1_full_n) |=> $stable(mail1_q)); // R2

    AST_M1_FLAG_MIN_HOLD: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $fell(mb1_full_n) |=> !mb1_full_n); // R3

    AST_M2_LOAD_FILLS: assert property (@(posedge clk_b) disable iff (!rst_b_n || !m2_data_rst_n)
        (b_m2_wr && mb2_full_n) |=> (!mb2_full_n && mail2_q == $past(din_b))); // R4

    AST_M2_LOAD_BLOCKED: assert property (@(posedge clk_b) disable iff (!rst_b_n || !m2_data_rst_n)
        (b_m2_wr && !mb2_full_n) |=> $stable(mail2_q)); // R4

    AST_M2_FLAG_MIN_HOLD: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $fell(mb2_full_n) |=> !mb2_full_n); // R5

    AST_FIFO_ROUTE: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_fifo_rd |=> (dout_b == $past(fifo_q_b))); // R6

    AST_A_OUT_HOLD: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !a_m2_rd |=> $stable(dout_a)); // R8

    AST_B_OUT_HOLD: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !(b_m1_rd || b_fifo_rd) |=> $stable(dout_b)); // R8
endmodule

bind mbox_bypass mbox_bypass_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a        (clk_a),
    .clk_b        (clk_b),
    .rst_a_n      (rst_a_n),
    .rst_b_n      (rst_b_n),
    .m2_data_rst_n(m2_data_rst_n),
    .a_m1_wr      (a_m1_wr),
    .a_m2_rd      (a_m2_rd),
    .b_m2_wr      (b_m2_wr),
    .b_m1_rd      (b_m1_rd),
    .b_fifo_rd    (b_fifo_rd),
    .mb1_full_n   (mb1_full_n),
    .mb2_full_n   (mb2_full_n),
    .din_a        (din_a),
    .din_b        (din_b),
    .fifo_q_b     (fifo_q_b),
    .mail1_q      (mail1_q),
    .mail2_q      (mail2_q),
    .dout_a       (dout_a),
    .dout_b       (dout_b)
);

// File: tb/mbox_bypass_bench.sv
module mbox_bypass_bench;
    localparam int W = 36;

    logic master_rst_n, part_rst_n, mail2_clr_n;
    logic clk_a, cs_a_n, en_a, wr_a, mbsel_a;
    logic clk_b, cs_b_n, en_b, rd_b, mbsel_b;
    logic [W-1:0] din_a, dout_a, din_b, fifo_q_b, dout_b;
    logic mb1_full_n, mb2_full_n;

    int n_vec, n_err, a_cnt, b_cnt;
    bit done;

    logic [W-1:0] m1_val, m2_val, exp_da, exp_db;
    logic         m1_full, m2_full;

    mbox_bypass u_mbox_bypass (
        .master_rst_n(master_rst_n), .part_rst_n(part_rst_n), .mail2_clr_n(mail2_clr_n),
        .clk_a(clk_a), .cs_a_n(cs_a_n), .en_a(en_a), .wr_a(wr_a), .mbsel_a(mbsel_a),
        .din_a(din_a), .dout_a(dout_a), .mb1_full_n(mb1_full_n),
        .clk_b(clk_b), .cs_b_n(cs_b_n), .en_b(en_b), .rd_b(rd_b), .mbsel_b(mbsel_b),
        .din_b(din_b), .fifo_q_b(fifo_q_b), .dout_b(dout_b), .mb2_full_n(mb2_full_n)
    );

    initial begin clk_a = 1'b0; forever #10 clk_a = ~clk_a; end
    initial begin clk_b = 1'b0; forever #13 clk_b = ~clk_b; end
    always @(posedge clk_a) a_cnt <= a_cnt + 1;
    always @(posedge clk_b) b_cnt <= b_cnt + 1;

    // expected-value functions
    function automatic logic [W-1:0] f_after_load(input logic full, input logic [W-1:0] old, input logic [W-1:0] d);
        return full ? old : d;
    endfunction
    function automatic logic f_flag_n(input logic full);
        return ~full;
    endfunction
    function automatic logic [W-1:0] rand36();
        logic [W-1:0] r;
        r[31:0]  = $urandom();
        r[35:32] = 4'($urandom());
        return r;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic a_access(input logic cs_n, input logic en, input logic wr, input logic mb,
                            input logic [W-1:0] d, output int mark_b);
        @(negedge clk_a);
        cs_a_n = cs_n; en_a = en; wr_a = wr; mbsel_a = mb; din_a = d;
        @(posedge clk_a);
        mark_b = b_cnt;
        @(negedge clk_a);
        cs_a_n = 1'b1; en_a = 1'b0; wr_a = 1'b0; mbsel_a = 1'b0;
    endtask

    task automatic b_access(input logic cs_n, input logic en, input logic rd, input logic mb,
                            input logic [W-1:0] d, input logic [W-1:0] fq, output int mark_a);
        @(negedge clk_b);
        cs_b_n = cs_n; en_b = en; rd_b = rd; mbsel_b = mb; din_b = d; fifo_q_b = fq;
        @(posedge clk_b);
        mark_a = a_cnt;
        @(negedge clk_b);
        cs_b_n = 1'b1; en_b = 1'b0; rd_b = 1'b0; mbsel_b = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk_b);
        repeat (5) @(negedge clk_a);
    endtask

    task automatic check_state(input string req);
        chk(req, W'(mb1_full_n), W'(f_flag_n(m1_full)));
        chk(req, W'(mb2_full_n), W'(f_flag_n(m2_full)));
        chk(req, dout_a, exp_da);
        chk(req, dout_b, exp_db);
    endtask

    task automatic op_a_load(input logic [W-1:0] d);
        int mk;
        a_access(1'b0, 1'b1, 1'b1, 1'b1, d, mk);
        chk(m1_full ? "R2" : "R1", W'(mb1_full_n), '0);
        m1_val  = f_after_load(m1_full, m1_val, d);
        m1_full = 1'b1;
    endtask

    task automatic op_b_load(input logic [W-1:0] d);
        int mk;
        b_access(1'b0, 1'b1, 1'b0, 1'b1, d, '0, mk);
        chk("R4", W'(mb2_full_n), '0);
        m2_val  = f_after_load(m2_full, m2_val, d);
        m2_full = 1'b1;
    endtask

    task automatic op_b_read_m1();
        int mk;
        b_access(1'b0, 1'b1, 1'b1, 1'b1, rand36(), rand36(), mk);
        exp_db = m1_val;
        chk(m1_full ? "R3" : "R7", dout_b, exp_db);
        if (m1_full) begin
            wait (a_cnt >= mk + 2);
            @(negedge clk_a);
            chk("R3", W'(mb1_full_n), '0);
            wait (a_cnt >= mk + 3);
            @(negedge clk_a);
            chk("R3", W'(mb1_full_n), W'(1));
        end else begin
            chk("R7", W'(mb1_full_n), W'(1));
        end
        m1_full = 1'b0;
    endtask

    task automatic op_a_read_m2();
        int mk;
        a_access(1'b0, 1'b1, 1'b0, 1'b1, rand36(), mk);
        exp_da = m2_val;
        chk(m2_full ? "R5" : "R7", dout_a, exp_da);
        if (m2_full) begin
            wait (b_cnt >= mk + 2);
            @(negedge clk_b);
            chk("R5", W'(mb2_full_n), '0);
            wait (b_cnt >= mk + 3);
            @(negedge clk_b);
            chk("R5", W'(mb2_full_n), W'(1));
        end else begin
            chk("R7", W'(mb2_full_n), W'(1));
        end
        m2_full = 1'b0;
    endtask

    task automatic op_fifo_read();
        int mk;
        logic [W-1:0] fq;
        fq = rand36();
        b_access(1'b0, 1'b1, 1'b1, 1'b0, rand36(), fq, mk);
        exp_db = fq;
        chk("R6", dout_b, exp_db);
    endtask

    task automatic op_disabled();
        int mk;
        logic cs_n, en;
        cs_n = 1'($urandom());
        en   = cs_n ? 1'($urandom()) : 1'b0;
        if (1'($urandom())) a_access(cs_n, en, 1'($urandom()), 1'b1, rand36(), mk);
        else                b_access(cs_n, en, 1'($urandom()), 1'($urandom()), rand36(), rand36(), mk);
    endtask

    initial begin
        n_vec = 0; n_err = 0; a_cnt = 0; b_cnt = 0; done = 1'b0;
        void'($urandom(32'd48611));
        master_rst_n = 1'b0; part_rst_n = 1'b1; mail2_clr_n = 1'b0;
        cs_a_n = 1'b1; en_a = 1'b0; wr_a = 1'b0; mbsel_a = 1'b0; din_a = '0;
        cs_b_n = 1'b1; en_b = 1'b0; rd_b = 1'b0; mbsel_b = 1'b0; din_b = '0; fifo_q_b = '0;
        m1_val = '0; m2_val = '0; m1_full = 1'b0; m2_full = 1'b0; exp_da = '0; exp_db = '0;
        repeat (6) @(negedge clk_b);
        master_rst_n = 1'b1; mail2_clr_n = 1'b1;
        settle();
        check_state("R9");

        // directed: load, blocked load, read back original word
        op_a_load(36'h1_2345_6789);
        op_a_load(36'hF_FFFF_0000);
        settle(); check_state("R2");
        op_b_read_m1(); settle(); check_state("R3");
        op_b_read_m1(); settle(); check_state("R7");

        op_b_load(36'hA_5A5A_5A5A);
        op_b_load(36'h0_0000_0001);
        settle(); check_state("R4");
        op_a_read_m2(); settle(); check_state("R5");

        // R11: non-mailbox loads touch neither mailbox
        begin
            int mk;
            a_access(1'b0, 1'b1, 1'b1, 1'b0, 36'h3_3333_3333, mk);
            b_access(1'b0, 1'b1, 1'b0, 1'b0, 36'h4_4444_4444, '0, mk);
            settle(); check_state("R11");
            op_b_read_m1(); op_a_read_m2(); settle(); check_state("R11");
        end

        // R10: clearing the second mailbox word keeps its flag
        op_b_load(36'h7_7777_7777);
        settle();
        mail2_clr_n = 1'b0;
        repeat (4) @(negedge clk_b);
        mail2_clr_n = 1'b1;
        settle();
        m2_val = '0;
        check_state("R10");
        op_a_read_m2(); settle(); check_state("R10");

        // R9: partial reset keeps both words, releases flags, zeros outputs
        op_a_load(36'h8_1111_2222);
        op_b_load(36'h9_3333_4444);
        settle();
        part_rst_n = 1'b0;
        repeat (6) @(negedge clk_b);
        part_rst_n = 1'b1;
        settle();
        m1_full = 1'b0; m2_full = 1'b0; exp_da = '0; exp_db = '0;
        check_state("R9");
        op_b_read_m1(); op_a_read_m2(); settle(); check_state("R9");

        // R9: master reset clears the first word
        op_a_load(36'hB_BBBB_CCCC); settle();
        master_rst_n = 1'b0;
        repeat (6) @(negedge clk_b);
        master_rst_n = 1'b1;
        settle();
        m1_full = 1'b0; m2_full = 1'b0; m1_val = '0; exp_da = '0; exp_db = '0;
        check_state("R9");
        op_b_read_m1(); settle(); check_state("R9");

        // constrained random mix
        for (int i = 0; i < 160; i++) begin
            int op;
            op = int'($urandom() % 6);
            case (op)
                0: op_a_load(rand36());
                1: op_b_read_m1();
                2: op_b_load(rand36());
                3: op_a_read_m2();
                4: op_fifo_read();
                default: op_disabled();
            endcase
            settle();
            check_state(op == 5 ? "R8" : (op == 4 ? "R6" : "R2"));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_a);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end
endmodule